// File: doc/BRIEF.md
# Configured-Instruction Sequencing ALU Tile

This block is a 16-bit arithmetic/logic tile that runs a tiny program held in eight configuration slots. It has no program counter and fetches nothing. Each slot holds one complete instruction. The slot addressed by the current state executes in a single cycle. In that same cycle a per-instruction bit expression picks which of four successor slots runs next.

Data enters on two operand words, A and B. Each word has 16 data bits, a valid flag and four independent sideband control bits. Results leave on an output word of the same shape. A one-bit status path carries a carry or a shifted-out bit between neighbouring tiles, so several tiles can be chained to build wider arithmetic.

The program is written through a narrow configuration port while the tile is halted. The tile is then started by raising the run input.

Top module: `seq_alu_tile`

## Requirements
- R1: While reset is high at a clock edge, the current slot becomes 0 and out_data, out_vld, out_ctl and stat_out become 0. Reset does not clear the program.
- R2: The opcode is the top four bits of the 71-bit instruction word. An executed instruction registers its result into out_data at the next edge. The codes are: 0 add, 1 subtract (A+~B+carry-in), 2 shift left by one, 3 shift right by one, 4 rotate left, 5 rotate right, 6 AND, 7 OR, 8 XOR, 9 select (B when stat_in is 1, else A). Any other code passes A through.
- R3: Instruction bit 66 is the cascade-enable bit. When it is set, stat_in is the carry-in (add, subtract) or the shift-in bit (shifts). When it is clear, the carry-in is 0 for add and 1 for subtract, and the shift-in is 0. Add and subtract load stat_out with the carry out. Shifts and rotates load it with the bit moved out. All other operations leave it unchanged.
- R4: The next slot is chosen from the 12-bit successor field (bits 11:0, three bits per entry, entry 0 lowest). The index into that field is a 2-bit code read from the 32-bit table at bits 43:12 (entry k at bits 2k+1:2k). Four 4-bit bit selectors at bits 59:44 form the 4-bit table address, selector i giving address bit i.
- R5: Source code s names one tile bit: 0..3 are A control bits 0..3, 4..7 are B control bits 0..3, 8 is A valid, 9 is B valid, 10 is stat_in, 11 is stat_out, 12 is A data bit 0, 13 is A data bit 15, 14 is B data bit 0, and 15 is B data bit 15.
- R6: The condition mode is bits 65:64 and the condition source is bits 63:60. The modes are: 0 always execute, 1 execute if the selected bit is 1, 2 execute if it is 0, 3 never execute. A non-executing instruction leaves out_data, out_ctl and stat_out unchanged and clears out_vld, but the slot still advances.
- R7: out_vld is 1 after an edge only if the instruction executed and A was valid. Add, subtract, logic and select also require B to be valid.
- R8: While run is low, the slot, out_data, out_ctl and stat_out hold and out_vld is 0.
- R9: A configuration write of cfg_word into slot cfg_slot takes effect only when run is low. A write while run is high is dropped.
- R10: On an executed instruction, out_ctl takes A's control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | 1 executes, 0 halts and opens configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | 3 | Slot to write |
| cfg_word | input | 71 | Instruction word to store |
| in_a_data | input | 16 | Operand A data |
| in_a_vld | input | 1 | Operand A valid |
| in_a_ctl | input | 4 | Operand A sideband control |
| in_b_data | input | 16 | Operand B data |
| in_b_vld | input | 1 | Operand B valid |
| in_b_ctl | input | 4 | Operand B sideband control |
| stat_in | input | 1 | Cascade status from neighbour |
| out_data | output | 16 | Registered result |
| out_vld | output | 1 | Registered result valid |
| out_ctl | output | 4 | Registered sideband control |
| stat_out | output | 1 | Registered status (carry or shift-out) |
| cur_slot | output | 3 | Slot that executes in the current cycle |

## Verification
Two events can fall in the same cycle: a configuration write, and execution of the slot being written. A write landing on a running tile must not disturb the slot that is about to execute, nor the slots that follow. The bench provokes this by writing a "never execute" word into a downstream slot while the program is running, then letting the program reach that slot. The behavioural model keeps the old program, so any accepted write shows up as a difference in out_vld or out_data on that cycle. A long random phase then mixes halts, writes and execution on every cycle.

// File: rtl/seq_alu_pkg.sv
package seq_alu_pkg;
  localparam int DW    = 16;
  localparam int CW    = 4;
  localparam int NSLOT = 8;
  localparam int SW    = $clog2(NSLOT);
  localparam int NBR   = 4;
  localparam int NSRC  = 16;
  localparam int SRCW  = $clog2(NSRC);
  localparam int NLUT  = 1 << NBR;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_SHL, OP_SHR, OP_ROL, OP_ROR,
    OP_AND, OP_OR, OP_XOR, OP_SEL, OP_PASS
  } op_e;

  typedef enum logic [1:0] {
    CM_ALWAYS, CM_IF1, CM_IF0, CM_NEVER
  } cmode_e;

  typedef struct packed {
    op_e                           op;
    logic                          use_cin;
    cmode_e                        cmode;
    logic [SRCW-1:0]               csrc;
    logic [NBR-1:0][SRCW-1:0]      bsel;
    logic [NLUT-1:0][1:0]          lut;
    logic [3:0][SW-1:0]            nxt;
  } instr_t;

  localparam int IW = $bits(instr_t);
endpackage

// File: rtl/seq_alu_store.sv
module seq_alu_store #(
  parameter int WIDTH = 71,
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/seq_alu_bitsel.sv
module seq_alu_bitsel #(
  parameter int NSRC  = 16,
  parameter int NPICK = 5,
  parameter int SRCW  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]             src,
  input  logic [NPICK-1:0][SRCW-1:0]  sel,
  output logic [NPICK-1:0]            bits
);
  for (genvar g = 0; g < NPICK; g++) begin : g_pick
    assign bits[g] = src[sel[g]];
  end
endmodule

// File: rtl/seq_alu_exec.sv
module seq_alu_exec
  import seq_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         use_cin,
  input  logic         stat_in,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         wr_stat,
  output logic         uses_b
);
  logic [W:0] sum;
  logic       sin;

  always_comb begin
    res     = a;
    cout    = 1'b0;
    wr_stat = 1'b0;
    uses_b  = 1'b0;
    sum     = '0;
    sin     = use_cin & stat_in;
    case (op)
      OP_ADD: begin
        sum     = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, sin};
        res     = sum[W-1:0];
        cout    = sum[W];
        wr_stat = 1'b1;
        uses_b  = 1'b1;
      end
      OP_SUB: begin
        sum     = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, (use_cin ? stat_in : 1'b1)};
        res     = sum[W-1:0];
        cout    = sum[W];
        wr_stat = 1'b1;
        uses_b  = 1'b1;
      end
      OP_SHL: begin
        res = {a[W-2:0], sin};  cout = a[W-1]; wr_stat = 1'b1;
      end
      OP_SHR: begin
        res = {sin, a[W-1:1]};  cout = a[0];   wr_stat = 1'b1;
      end
      OP_ROL: begin
        res = {a[W-2:0], a[W-1]}; cout = a[W-1]; wr_stat = 1'b1;
      end
      OP_ROR: begin
        res = {a[0], a[W-1:1]};   cout = a[0];   wr_stat = 1'b1;
      end
      OP_AND: begin res = a & b; uses_b = 1'b1; end
      OP_OR:  begin res = a | b; uses_b = 1'b1; end
      OP_XOR: begin res = a ^ b; uses_b = 1'b1; end
      OP_SEL: begin res = stat_in ? b : a; uses_b = 1'b1; end
      default: res = a;
    endcase
  end
endmodule

// File: rtl/seq_alu_tile.sv
module seq_alu_tile
  import seq_alu_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_slot,
  input  logic [IW-1:0] cfg_word,
  input  logic [DW-1:0] in_a_data,
  input  logic          in_a_vld,
  input  logic [CW-1:0] in_a_ctl,
  input  logic [DW-1:0] in_b_data,
  input  logic          in_b_vld,
  input  logic [CW-1:0] in_b_ctl,
  input  logic          stat_in,
  output logic [DW-1:0] out_data,
  output logic          out_vld,
  output logic [CW-1:0] out_ctl,
  output logic          stat_out,
  output logic [SW-1:0] cur_slot
);
  localparam int NPICK = NBR + 1;

  logic [IW-1:0]              rd_word;
  instr_t                     ins;
  logic [NSRC-1:0]            src;
  logic [NPICK-1:0][SRCW-1:0] picks_sel;
  logic [NPICK-1:0]           picks;
  logic [NBR-1:0]             lut_addr;
  logic [1:0]                 br;
  logic                       cond_ok, exec;
  logic [DW-1:0]              res;
  logic                       cout, wr_stat, uses_b;

  // program slots: written only while halted
  seq_alu_store #(.WIDTH(IW), .DEPTH(NSLOT)) u_store (
    .clk   (clk),
    .we    (cfg_we & ~run),
    .waddr (cfg_slot),
    .wdata (cfg_word),
    .raddr (cur_slot),
    .rdata (rd_word)
  );

  assign ins = rd_word;

  // selectable bit sources, code order fixed by the instruction format
  assign src = {in_b_data[DW-1], in_b_data[0], in_a_data[DW-1], in_a_data[0],
                stat_out, stat_in, in_b_vld, in_a_vld, in_b_ctl, in_a_ctl};

  assign picks_sel = {ins.csrc, ins.bsel};

  seq_alu_bitsel #(.NSRC(NSRC), .NPICK(NPICK)) u_bitsel (
    .src  (src),
    .sel  (picks_sel),
    .bits (picks)
  );

  assign lut_addr = picks[NBR-1:0];
  assign br       = ins.lut[lut_addr];

  always_comb begin
    case (ins.cmode)
      CM_ALWAYS: cond_ok = 1'b1;
      CM_IF1:    cond_ok = picks[NBR];
      CM_IF0:    cond_ok = ~picks[NBR];
      default:   cond_ok = 1'b0;
    endcase
  end

  assign exec = run & cond_ok;

  seq_alu_exec #(.W(DW)) u_exec (
    .op      (ins.op),
    .a       (in_a_data),
    .b       (in_b_data),
    .use_cin (ins.use_cin),
    .stat_in (stat_in),
    .res     (res),
    .cout    (cout),
    .wr_stat (wr_stat),
    .uses_b  (uses_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_slot <= '0;
      out_data <= '0;
      out_vld  <= 1'b0;
      out_ctl  <= '0;
      stat_out <= 1'b0;
    end else begin
      out_vld <= exec & in_a_vld & (in_b_vld | ~uses_b);
      if (run) cur_slot <= ins.nxt[br];
      if (exec) begin
        out_data <= res;
        out_ctl  <= in_a_ctl;
        if (wr_stat) stat_out <= cout;
      end
    end
  end
endmodule

// File: rtl/seq_alu_chk.sv
module seq_alu_chk
  import seq_alu_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic          in_a_vld,
  input logic [SW-1:0] cur_slot,
  input logic [DW-1:0] out_data,
  input logic          out_vld,
  input logic [CW-1:0] out_ctl,
  input logic          stat_out
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (cur_slot == '0 && !out_vld && out_data == '0 && !stat_out)); // R1

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(cur_slot) && $stable(out_data) && $stable(out_ctl) && $stable(stat_out))); // R8

  AST_HALT_NO_VLD: assert property (@(posedge clk) disable iff (rst) !run |=> !out_vld); // R8

  AST_VLD_NEEDS_A: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> ($past(in_a_vld) && $past(run))); // R7
endmodule

bind seq_alu_tile seq_alu_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .run      (run),
  .in_a_vld (in_a_vld),
  .cur_slot (cur_slot),
  .out_data (out_data),
  .out_vld  (out_vld),
  .out_ctl  (out_ctl),
  .stat_out (stat_out)
);

// File: tb/test_seq_alu_tile.sv
`timescale 1ns/1ps
module test_seq_alu_tile;
  import seq_alu_pkg::*;

  logic          clk = 1'b0;
  logic          rst, run, cfg_we, stat_in;
  logic [SW-1:0] cfg_slot;
  logic [IW-1:0] cfg_word;
  logic [DW-1:0] in_a_data, in_b_data;
  logic          in_a_vld, in_b_vld;
  logic [CW-1:0] in_a_ctl, in_b_ctl;
  logic [DW-1:0] out_data;
  logic          out_vld, stat_out;
  logic [CW-1:0] out_ctl;
  logic [SW-1:0] cur_slot;

  seq_alu_tile i_seq_alu_tile (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural model state
  instr_t prog [NSLOT];
  int     m_slot, m_data, m_ctl;
  bit     m_vld, m_stat;

  task automatic check(string req, string ph, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s [%s] got %0h expected %0h", req, ph, got, exp);
    end
  endtask

  task automatic compare(string ph);
    check("R4 slot", ph, int'(cur_slot), m_slot);
    check("R2 data", ph, int'(out_data), m_data);
    check("R3 status", ph, int'(stat_out), int'(m_stat));
    check("R7 valid", ph, int'(out_vld), int'(m_vld));
    check("R10 ctl", ph, int'(out_ctl), m_ctl);
  endtask

  // R5 source codes
  function automatic bit src_bit(int code);
    case (code)
      0, 1, 2, 3:     return in_a_ctl[code];
      4, 5, 6, 7:     return in_b_ctl[code-4];
      8:  return in_a_vld;
      9:  return in_b_vld;
      10: return stat_in;
      11: return m_stat;
      12: return in_a_data[0];
      13: return in_a_data[15];
      14: return in_b_data[0];
      default: return in_b_data[15];
    endcase
  endfunction

  task automatic cycle(string ph);
    int  n_slot, n_data, n_ctl;
    bit  n_vld, n_stat;
    instr_t p;
    int  a, b, opc, s, res, idx, br;
    bit  si, ci, st, wst, usesb, cond;
    p = prog[m_slot];
    n_slot = m_slot; n_data = m_data; n_ctl = m_ctl; n_stat = m_stat; n_vld = 0;
    a = int'(in_a_data); b = int'(in_b_data); opc = int'(p.op);
    si = p.use_cin ? stat_in : 1'b0;
    st = 0; wst = 0; usesb = 0; res = a;
    case (opc)
      0: begin s = a + b + int'(si); res = s & 16'hFFFF; st = s[16]; wst = 1; usesb = 1; end
      1: begin s = a + (b ^ 16'hFFFF) + (p.use_cin ? int'(stat_in) : 1);
               res = s & 16'hFFFF; st = s[16]; wst = 1; usesb = 1; end
      2: begin res = ((a << 1) | int'(si)) & 16'hFFFF; st = a[15]; wst = 1; end
      3: begin res = (a >> 1) | (int'(si) << 15); st = a[0]; wst = 1; end
      4: begin res = ((a << 1) | (a >> 15)) & 16'hFFFF; st = a[15]; wst = 1; end
      5: begin res = (a >> 1) | ((a & 1) << 15); st = a[0]; wst = 1; end
      6: begin res = a & b; usesb = 1; end
      7: begin res = a | b; usesb = 1; end
      8: begin res = a ^ b; usesb = 1; end
      9: begin res = stat_in ? b : a; usesb = 1; end
      default: res = a;
    endcase
    case (int'(p.cmode))
      0: cond = 1;
      1: cond = src_bit(int'(p.csrc));
      2: cond = !src_bit(int'(p.csrc));
      default: cond = 0;
    endcase
    idx = 0;
    for (int i = 0; i < 4; i++) idx += int'(src_bit(int'(p.bsel[i]))) << i;
    br = int'(p.lut[idx]);
    if (run) begin
      n_slot = int'(p.nxt[br]);
      if (cond) begin
        n_data = res; n_ctl = int'(in_a_ctl);
        if (wst) n_stat = st;
        n_vld = in_a_vld && (in_b_vld || !usesb);
      end
    end
    if (rst) begin
      n_slot = 0; n_data = 0; n_ctl = 0; n_stat = 0; n_vld = 0;
    end
    if (cfg_we && !run) prog[cfg_slot] = instr_t'(cfg_word);  // R9
    @(posedge clk);
    m_slot = n_slot; m_data = n_data; m_ctl = n_ctl; m_stat = n_stat; m_vld = n_vld;
    @(negedge clk);
    if (!done) compare(ph);
  endtask

  function automatic instr_t mk(int op, bit uc, int cm, int cs, logic [15:0] bs,
                                logic [31:0] lt, logic [11:0] nx);
    instr_t w;
    w.op = op_e'(op); w.use_cin = uc; w.cmode = cmode_e'(cm); w.csrc = 4'(cs);
    w.bsel = bs; w.lut = lt; w.nxt = nx;
    return w;
  endfunction

  task automatic drive(logic [15:0] a, logic [15:0] b, bit av, bit bv,
                       logic [3:0] ac, logic [3:0] bc, bit si);
    in_a_data = a; in_b_data = b; in_a_vld = av; in_b_vld = bv;
    in_a_ctl = ac; in_b_ctl = bc; stat_in = si;
  endtask

  task automatic load(int slot, instr_t w);
    cfg_we = 1; cfg_slot = 3'(slot); cfg_word = w;
    cycle("R9 load");
    cfg_we = 0;
  endtask

  function automatic logic [11:0] all_to(int s);
    return {4{3'(s)}};
  endfunction

  initial begin
    rst = 1; run = 0; cfg_we = 0; cfg_slot = 0; cfg_word = '0;
    drive(16'h0, 16'h0, 0, 0, 4'h0, 4'h0, 0);
    m_slot = 0; m_data = 0; m_ctl = 0; m_stat = 0; m_vld = 0;
    for (int i = 0; i < NSLOT; i++) prog[i] = '0;
    @(negedge clk);
    cycle("R1 reset");
    cycle("R1 reset");
    rst = 0;
    // slot0: add with cascade; all selectors read A ctl0; lut[15]=1 -> slot1, else stay
    load(0, mk(0, 1, 0, 0, 16'h0000, 32'h4000_0000, {3'd0, 3'd0, 3'd1, 3'd0}));
    // slot1: subtract, executes only if B valid (code 9)
    load(1, mk(1, 0, 1, 9, 16'h0000, 32'h0, all_to(2)));
    load(2, mk(2, 1, 0, 0, 16'h0000, 32'h0, all_to(3)));
    load(3, mk(5, 0, 0, 0, 16'h0000, 32'h0, all_to(4)));
    // slot4: xor, never executes (R6)
    load(4, mk(8, 0, 3, 0, 16'h0000, 32'h0, all_to(5)));
    // slot5: select, executes if A ctl2 is 0
    load(5, mk(9, 0, 2, 2, 16'h0000, 32'h0, all_to(6)));
    load(6, mk(3, 1, 0, 0, 16'h0000, 32'h0, all_to(7)));
    // slot7: and; selectors stat_in, A bit0, B bit15, A valid; lut[k]=k mod 4
    load(7, mk(6, 0, 0, 0, 16'h8_F_C_A, 32'hE4E4_E4E4, {3'd7, 3'd5, 3'd3, 3'd0}));
    cycle("R1 idle");

    // directed walk
    run = 1;
    drive(16'hFFFF, 16'h0001, 1, 1, 4'h0, 4'h5, 1);
    cycle("R3 add carry cascade");              // FFFF+1+1 -> 0001, carry 1, stay 0
    drive(16'h1234, 16'h1111, 1, 0, 4'h6, 4'h0, 0);
    cycle("R7 add missing B valid");
    // R9: write while running must be dropped (slot 3 would become never-execute pass)
    cfg_we = 1; cfg_slot = 3; cfg_word = mk(10, 0, 3, 0, 16'h0, 32'h0, all_to(0));
    drive(16'h0000, 16'h0000, 1, 1, 4'hF, 4'h0, 0);
    cycle("R4 branch to slot1 with dropped R9 write");
    cfg_we = 0;
    drive(16'h0005, 16'h0007, 1, 1, 4'h2, 4'h0, 0);
    cycle("R6 sub executes, borrow");
    drive(16'h8001, 16'h0, 1, 0, 4'h3, 4'h0, 1);
    cycle("R3 shl shift-in");
    drive(16'h0003, 16'h0, 1, 0, 4'h1, 4'h0, 1);
    cycle("R9 ror in slot written while running");
    drive(16'hAAAA, 16'h5555, 1, 1, 4'h9, 4'h0, 0);
    cycle("R6 never executes");
    drive(16'h1111, 16'h2222, 1, 1, 4'h0, 4'h0, 1);
    cycle("R5 select B by stat_in");
    // halt with wild inputs
    run = 0;
    for (int i = 0; i < 3; i++) begin
      drive(16'($urandom), 16'($urandom), 1, 1, 4'($urandom), 4'($urandom), 1'($urandom));
      cycle("R8 halt holds");
    end
    run = 1;
    drive(16'h8000, 16'h0, 1, 0, 4'h0, 4'h0, 1);
    cycle("R3 shr with cascade in");
    drive(16'h00F1, 16'h80FF, 1, 1, 4'h4, 4'h0, 1);
    cycle("R4 lut branch from slot7");

    // random mix
    for (int i = 0; i < 2000; i++) begin
      run = ($urandom % 4) != 0;
      cfg_we = ($urandom % 5) == 0;
      cfg_slot = 3'($urandom);
      cfg_word = {7'($urandom), $urandom, $urandom};
      drive(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
            4'($urandom), 4'($urandom), 1'($urandom));
      cycle("R2 random");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule